// File: doc/BRIEF.md
# 64b/66b Transmit Scrambler and 66-to-16 Gearbox

This block is the transmit half of a 64b/66b line path, between the block encoder and a bit serializer. Each accepted input block is a 64-bit payload with a 2-bit sync header. The payload goes through a self-synchronising scrambler with polynomial x^58 + x^39 + 1, and the header bypasses it. The 66-bit result goes into a gearbox that emits a continuous stream of 16-bit words for the serializer.

A single clock drives both sides. The gearbox holds leftover bits between blocks and asks for a new block only when fewer than one output word of bits remains. Under a steady supply, the handshake accepts 8 blocks in every 33 cycles and a word leaves on every cycle. A header that carries no transition (00 or 11) is still sent unchanged, and it sets a sticky error flag.

Top module: `tx_scr_gearbox`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `out_valid` and `hdr_err` are all 0.
- R2: On the line, each 66-bit block starts with header bit 0, then header bit 1, then the 64 scrambled payload bits from bit 0 upward. In every output word, bit 0 is the earliest bit.
- R3: Scrambled bit s = d ^ s(39 bits earlier) ^ s(58 bits earlier). Only the payload is scrambled, and the state advances only on accepted blocks. The 58-bit history resets to 58'h2_5A3C_96E1_0F4B_D7, with its bit 57 as the most recent scrambled bit and bit 0 as the oldest.
- R4: The valid output words, joined in order, equal the accepted blocks joined in order, with no bit lost, repeated or inserted.
- R5: `in_ready` is high only when fewer than 16 bits are pending, so no block is accepted in two consecutive cycles.
- R6: With `in_valid` held high from an empty state, exactly 8 blocks are accepted in every 33 cycles, and `out_valid` stays high on every cycle.
- R7: When fewer than 16 bits are pending and no block arrives, `out_valid` is 0. The stream resumes intact when blocks return.
- R8: A block accepted while the gearbox is empty makes `out_valid` high in the cycle right after acceptance.
- R9: An accepted header of 00 or 11 sets `hdr_err` in the next cycle. The header is sent unchanged, and `hdr_err` stays set until reset.
- R10: Headers 01 and 10 never set `hdr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the input and the output side |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | An input block is offered |
| in_ready | output | 1 | The gearbox can take a block in this cycle |
| in_hdr | input | 2 | Sync header, bit 0 sent first |
| in_data | input | 64 | Payload, bit 0 sent first after the header |
| out_word | output | 16 | Line word, bit 0 earliest |
| out_valid | output | 1 | `out_word` carries stream bits |
| hdr_err | output | 1 | Sticky flag for an accepted header without a transition |

## Verification
Every result comes from a register one edge after the acceptance that causes it. The first word of a block that arrives at an empty gearbox, and the error flag after a bad header, both show in the cycle after the accepting edge. A scoreboard queues each block at handover. A monitor samples `out_word` on the falling edge, rebuilds 66-bit blocks from a known start, descrambles them with its own history, and compares them in order. Acceptance cycles are logged on the same falling edge, so the 8-in-33 rhythm and the rule against back-to-back acceptance are measured as cycle differences, not as points in time.

// File: rtl/tx_scr_gearbox_pkg.sv
package tx_scr_gearbox_pkg;
  localparam int unsigned PAY_W = 64;
  localparam int unsigned HDR_W = 2;
  localparam int unsigned LINE_W = 16;
  localparam int unsigned SCR_LEN = 58;
  localparam int unsigned SCR_TAP = 39;
  localparam logic [SCR_LEN-1:0] SCR_SEED = 58'h2_5A3C_96E1_0F4B_D7;

  typedef enum logic [HDR_W-1:0] {
    HDR_DATA = 2'b01,
    HDR_CTRL = 2'b10
  } sync_hdr_e;

  function automatic logic hdr_has_edge(input logic [HDR_W-1:0] h);
    return (h == HDR_DATA) || (h == HDR_CTRL);
  endfunction
endpackage

// File: rtl/pay_scrambler.sv
module pay_scrambler #(
  parameter int unsigned DW = 64,
  parameter int unsigned LEN = 58,
  parameter int unsigned TAP = 39,
  parameter logic [LEN-1:0] SEED = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int unsigned EXT_W = LEN + DW;
  localparam int unsigned BACK = LEN - TAP;

  logic [LEN-1:0] hist_q;
  logic [LEN-1:0] hist_d;
  logic [EXT_W-1:0] ext;

  assign ext[LEN-1:0] = hist_q;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign ext[LEN+i] = din[i] ^ ext[i+BACK] ^ ext[i];
  end

  assign dout = ext[EXT_W-1:LEN];

  always_comb begin
    hist_d = hist_q;
    if (adv) hist_d = ext[EXT_W-1:EXT_W-LEN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= SEED;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/hdr_watch.sv
module hdr_watch
  import tx_scr_gearbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [HDR_W-1:0] hdr,
  output logic             err
);
  logic err_q;
  logic err_d;

  always_comb begin
    err_d = err_q;
    if (take && !hdr_has_edge(hdr)) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;
endmodule

// File: rtl/blk_gearbox.sv
module blk_gearbox #(
  parameter int unsigned BLK_W = 66,
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] blk,
  output logic             want,
  output logic [OUT_W-1:0] word,
  output logic             word_vld
);
  localparam int unsigned BUF_W = BLK_W + OUT_W - 1;
  localparam int unsigned CNT_W = $clog2(BUF_W + 1);
  localparam logic [CNT_W-1:0] OUT_CNT = CNT_W'(OUT_W);
  localparam logic [CNT_W-1:0] BLK_CNT = CNT_W'(BLK_W);

  logic [BUF_W-1:0] res_q, res_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OUT_W-1:0] word_q, word_d;
  logic             vld_q, vld_d;
  logic [BUF_W-1:0] merged;
  logic [CNT_W-1:0] avail;
  logic             emit;
  logic             res_en;

  always_comb begin
    merged = res_q;
    avail  = cnt_q;
    if (load) begin
      merged = res_q | ({{(BUF_W-BLK_W){1'b0}}, blk} << cnt_q);
      avail  = cnt_q + BLK_CNT;
    end
    emit   = (avail >= OUT_CNT);
    res_en = load | emit;
    vld_d  = emit;
    word_d = merged[OUT_W-1:0];
    res_d  = merged;
    cnt_d  = avail;
    if (emit) begin
      res_d = merged >> OUT_W;
      cnt_d = avail - OUT_CNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      cnt_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (emit) word_q <= word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign want     = (cnt_q < OUT_CNT);
  assign word     = word_q;
  assign word_vld = vld_q;
endmodule

// File: rtl/tx_scr_gearbox.sv
module tx_scr_gearbox
  import tx_scr_gearbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HDR_W-1:0]  in_hdr,
  input  logic [PAY_W-1:0]  in_data,
  output logic [LINE_W-1:0] out_word,
  output logic              out_valid,
  output logic              hdr_err
);
  localparam int unsigned BLK_W = PAY_W + HDR_W;

  logic rst_meta_q, rst_sync_q;
  logic take;
  logic want;
  logic [PAY_W-1:0] scr_pay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign in_ready = want & rst_sync_q;
  assign take     = in_valid & in_ready;

  pay_scrambler #(
    .DW(PAY_W), .LEN(SCR_LEN), .TAP(SCR_TAP), .SEED(SCR_SEED)
  ) u_scr (
    .clk(clk), .rst_n(rst_sync_q), .adv(take), .din(in_data), .dout(scr_pay)
  );

  hdr_watch u_hdr (
    .clk(clk), .rst_n(rst_sync_q), .take(take), .hdr(in_hdr), .err(hdr_err)
  );

  blk_gearbox #(.BLK_W(BLK_W), .OUT_W(LINE_W)) u_gbx (
    .clk(clk), .rst_n(rst_sync_q), .load(take), .blk({scr_pay, in_hdr}),
    .want(want), .word(out_word), .word_vld(out_valid)
  );
endmodule

// File: rtl/tx_scr_gearbox_chk.sv
module tx_scr_gearbox_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_hdr,
  input logic       out_valid,
  input logic       hdr_err
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!in_ready && !out_valid && !hdr_err);
    end
  end

  assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_word_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_bad_hdr_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_hdr == 2'b00 || in_hdr == 2'b11)) |=> hdr_err);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |=> hdr_err);

  assert_err_only_on_bad_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_err) |-> $past(in_valid && in_ready && (in_hdr == 2'b00 || in_hdr == 2'b11)));
endmodule

bind tx_scr_gearbox tx_scr_gearbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_hdr(in_hdr), .out_valid(out_valid), .hdr_err(hdr_err)
);

// File: tb/tx_scr_gearbox_tb_top.sv
module tx_scr_gearbox_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_hdr = 2'b01;
  logic [63:0] in_data = '0;
  logic in_ready, out_valid, hdr_err;
  logic [15:0] out_word;

  int checks = 0, errors = 0, cyc = 0, consec = 0, gaps = 0;
  bit burst_on = 0, done = 0, first_blk = 1;
  logic [65:0] exp_q[$];
  bit bitq[$];
  int acc[$];
  logic [57:0] hist = 58'h2_5A3C_96E1_0F4B_D7;

  always #10 clk = ~clk;

  tx_scr_gearbox dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_data(in_data), .out_word(out_word),
    .out_valid(out_valid), .hdr_err(hdr_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] h, input logic [63:0] d);
    in_valid = 1'b1; in_hdr = h; in_data = d;
    while (!in_ready) begin @(posedge clk); #2; end
    exp_q.push_back({d, h});
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && in_valid && in_ready) begin
      if (acc.size() > 0 && acc[acc.size()-1] == cyc - 1) consec++;
      acc.push_back(cyc);
    end
    if (burst_on && !out_valid) gaps++;
  end

  always @(negedge clk) begin
    logic [1:0] h;
    logic [63:0] raw, plain;
    logic [65:0] e;
    if (rst_n && out_valid) begin
      for (int b = 0; b < 16; b++) bitq.push_back(out_word[b]);
      while (bitq.size() >= 66) begin
        h[0] = bitq.pop_front();
        h[1] = bitq.pop_front();
        for (int i = 0; i < 64; i++) begin
          raw[i] = bitq.pop_front();
          plain[i] = raw[i] ^ hist[19] ^ hist[0];
          hist = {raw[i], hist[57:1]};
        end
        if (exp_q.size() == 0) begin
          chk(0, "R4", "unexpected block", {h, plain}, 0);
        end else begin
          e = exp_q.pop_front();
          chk(h == e[1:0], "R2", "header bits", h, e[1:0]);
          chk(plain == e[65:2], "R3/R4", "descrambled payload", plain, e[65:2]);
          if (first_blk) chk(raw != e[65:2], "R3", "payload scrambled on line", raw, ~e[65:2]);
          first_blk = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!in_ready && !out_valid && !hdr_err, "R1", "outputs in reset",
        {in_ready, out_valid, hdr_err}, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    idle(3);
    chk(!out_valid, "R7", "idle before data", out_valid, 0);
    // R8: first block into an empty gearbox
    send(2'b01, 64'h0);
    chk(out_valid, "R8", "word right after acceptance", out_valid, 1);
    idle(8);
    chk(!out_valid, "R7", "starved output", out_valid, 0);
    // R6/R5: sustained supply
    acc.delete();
    in_valid = 1'b1;
    send(2'b10, 64'h0123_4567_89AB_CDEF);
    burst_on = 1;
    for (int k = 1; k < 17; k++) send(k[0] ? 2'b01 : 2'b10, {32'hA5A5_0000 + k, 32'(k * 7919)});
    burst_on = 0;
    chk(acc.size() == 17, "R6", "burst accepted count", acc.size(), 17);
    if (acc.size() == 17) begin
      chk(acc[8] - acc[0] == 33, "R6", "cycles per 8 blocks (1st)", acc[8] - acc[0], 33);
      chk(acc[16] - acc[8] == 33, "R6", "cycles per 8 blocks (2nd)", acc[16] - acc[8], 33);
    end
    chk(gaps == 0, "R6", "missing words in burst", gaps, 0);
    // R7: irregular supply
    for (int k = 0; k < 40; k++) begin
      send(($urandom % 2) ? 2'b01 : 2'b10, {$urandom, $urandom});
      idle($urandom % 6);
    end
    chk(consec == 0, "R5", "back-to-back acceptances", consec, 0);
    chk(!hdr_err, "R10", "flag after good headers", hdr_err, 0);
    // R9: bad headers
    send(2'b11, 64'hDEAD_BEEF_0000_FFFF);
    chk(hdr_err, "R9", "flag after header 11", hdr_err, 1);
    send(2'b01, 64'h1);
    send(2'b00, 64'h2);
    idle(4);
    chk(hdr_err, "R9", "flag stays set", hdr_err, 1);
    send(2'b10, 64'h3);
    send(2'b01, 64'h4);
    while (exp_q.size() > 1) begin @(posedge clk); #2; end
    idle(4);
    chk(exp_q.size() <= 1, "R4", "blocks left undelivered", exp_q.size(), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule